// File: doc/BRIEF.md
# I2C Write-Only Slave Receiver with Overflow Handling

This block is a 7-bit-address I2C slave that only accepts master writes. It samples the bus clock and data lines through two-flop synchronisers running on the system clock. It detects START and STOP conditions and compares the first byte of each transfer against a programmable own address. On a hit it receives the following bytes into a single-byte receive buffer. The slave drives the data line low (open-drain) to acknowledge a byte on the ninth clock, but only when reception is allowed.

A host-side register view shows the following:
- a buffer-full flag;
- a sticky overflow flag;
- a read/write status bit;
- a per-byte interrupt flag.

The ACK and buffer-load decision for each byte comes from a four-row table over buffer-full and overflow. In one row the block loads the buffer and still answers NACK: this is when the host emptied the buffer but left overflow set. The host clears overflow and interrupt with one-cycle strobes, and a read strobe on the buffer clears buffer-full.

The receive sequencer has six states:
- `ST_IDLE`: the bus is unused.
- `ST_ADDR`: shifting the address byte.
- `ST_ADDR_ACK`: ninth clock after a matching write address.
- `ST_DATA`: shifting a data byte.
- `ST_DATA_ACK`: ninth clock after a data byte.
- `ST_IGNORE`: a non-matching or read transfer is being skipped.

It has these transitions:
- START from any state goes to `ST_ADDR`.
- STOP from any state goes to `ST_IDLE`.
- `ST_ADDR` on the eighth falling clock goes to `ST_ADDR_ACK` on a write hit, and to `ST_IGNORE` otherwise.
- `ST_ADDR_ACK` and `ST_DATA_ACK` on the ninth falling clock go to `ST_DATA`.
- `ST_DATA` on the eighth falling clock goes to `ST_DATA_ACK`.

Top module: `i2c_rx_slave`

## Requirements
- R1: After reset `buf_full`, `ovf`, `irq` and `sda_oe` are 0, and `rw_stat` is 1.
- R2: A falling data line while the clock line is high is a START. A START in any state, including in the middle of a byte, restarts address reception. A rising data line while the clock is high is a STOP and returns the block to idle, where clock pulses are ignored.
- R3: An address byte whose upper seven bits equal `own_addr` and whose LSB (R/W) is 0 clears `rw_stat`. When neither flag is set, the address byte is acknowledged.
- R4: A byte is shifted in MSB first and its end is the falling edge of the eighth clock pulse. A matching address byte enters the buffer as `{own_addr, 1'b0}`.
- R5: With buffer-full 0 and overflow 0 at byte end, the byte is loaded, `buf_full` is set and ACK is driven.
- R6: With buffer-full 1 and overflow 0 at byte end, the buffer keeps its old value, NACK is given and `ovf` is set.
- R7: With buffer-full 1 and overflow 1 at byte end, the buffer keeps its old value, NACK is given and `ovf` stays 1.
- R8: With buffer-full 0 and overflow 1 at byte end, the byte is loaded and `buf_full` is set, but NACK is given and `ovf` stays 1.
- R9: `irq` is set at the end of every accepted byte, whether it is ACKed or NACKed. Only `clr_irq` clears it.
- R10: A `rd_buf` strobe clears `buf_full` from the next cycle. A `clr_ovf` strobe clears `ovf`.
- R11: An address mismatch or a read request (LSB 1) gets NACK. The flags stay unchanged, and later bytes are ignored until the next START.
- R12: `sda_oe` is 1 only from the end of an acknowledged byte to the falling edge of the ninth clock pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | 1 pulls the data line low, 0 releases it |
| own_addr | input | 7 | Programmable slave address |
| rd_buf | input | 1 | Host read strobe for the receive buffer |
| clr_ovf | input | 1 | Host strobe clearing the overflow flag |
| clr_irq | input | 1 | Host strobe clearing the interrupt flag |
| rx_buf | output | 8 | Receive buffer contents |
| buf_full | output | 1 | Buffer holds an unread byte |
| ovf | output | 1 | Sticky overflow flag |
| rw_stat | output | 1 | Read/write status, cleared by a matching write address |
| irq | output | 1 | Per-byte interrupt flag |

## Verification
The buffer and ACK path is driven with bytes arriving in each of the four combinations of buffer-full and overflow. Sampling the ninth-clock line level, the buffer value and the flags separates the load/NACK row from the two no-load rows and from the normal ACK row. Address bytes are sent with a matching write, a wrong address and a matching read, to separate acceptance from ignoring. Three further patterns show that restart and idle behaviour are honoured rather than bytes simply being counted: a repeated START in the middle of a byte, clock pulses after a STOP, and bytes that vary in their MSB and LSB.

// File: rtl/i2c_rx_pkg.sv
package i2c_rx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_DATA,
        ST_DATA_ACK,
        ST_IGNORE
    } rx_state_t;

    typedef struct packed {
        logic load;
        logic ack;
        logic set_ov;
    } rx_action_t;

    // Per-byte action from the current buffer-full / overflow pair.
    function automatic rx_action_t rx_decide(input logic full, input logic ov);
        rx_action_t a;
        unique case ({full, ov})
            2'b00:   a = '{load: 1'b1, ack: 1'b1, set_ov: 1'b0};
            2'b10:   a = '{load: 1'b0, ack: 1'b0, set_ov: 1'b1};
            2'b11:   a = '{load: 1'b0, ack: 1'b0, set_ov: 1'b0};
            default: a = '{load: 1'b1, ack: 1'b0, set_ov: 1'b0};
        endcase
        return a;
    endfunction

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
    parameter int LINES  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] raw,
    output logic [LINES-1:0] level,
    output logic [LINES-1:0] rise,
    output logic [LINES-1:0] fall
);
    generate
        for (genvar g = 0; g < LINES; g++) begin : g_line
            logic [STAGES-1:0] chain;
            logic              prev;

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    chain <= '1;
                    prev  <= 1'b1;
                end else begin
                    chain <= {chain[STAGES-2:0], raw[g]};
                    prev  <= chain[STAGES-1];
                end
            end

            assign level[g] = chain[STAGES-1];
            assign rise[g]  = chain[STAGES-1] & ~prev;
            assign fall[g]  = ~chain[STAGES-1] & prev;
        end
    endgenerate
endmodule

// File: rtl/i2c_bus_events.sv
module i2c_bus_events (
    input  logic scl_lvl,
    input  logic sda_rise,
    input  logic sda_fall,
    output logic start_ev,
    output logic stop_ev
);
    always_comb begin
        start_ev = sda_fall & scl_lvl;
        stop_ev  = sda_rise & scl_lvl;
    end
endmodule

// File: rtl/i2c_rx_fsm.sv
module i2c_rx_fsm
    import i2c_rx_pkg::*;
#(
    parameter int ADDR_W = 7
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            scl_rise,
    input  logic            scl_fall,
    input  logic            sda_lvl,
    input  logic            start_ev,
    input  logic            stop_ev,
    input  logic [ADDR_W-1:0] own_addr,
    input  logic            ack_ok,
    output rx_state_t       state,
    output logic            byte_done,
    output logic            byte_is_addr,
    output logic [ADDR_W:0] byte_val,
    output logic            sda_oe
);
    localparam int DATA_W = ADDR_W + 1;
    localparam int CNT_W  = $clog2(DATA_W + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W);

    rx_state_t         nxt;
    logic [CNT_W-1:0]  cnt;
    logic [DATA_W-1:0] shreg;
    logic              drive;
    logic              byte_end;
    logic              addr_hit;

    assign byte_end = scl_fall && (cnt == LAST);
    assign addr_hit = (shreg[DATA_W-1:1] == own_addr) && !shreg[0];

    // next-state logic
    always_comb begin
        nxt = state;
        if (start_ev) begin
            nxt = ST_ADDR;
        end else if (stop_ev) begin
            nxt = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE, ST_IGNORE: nxt = state;
                ST_ADDR: begin
                    if (byte_end) nxt = addr_hit ? ST_ADDR_ACK : ST_IGNORE;
                end
                ST_DATA: begin
                    if (byte_end) nxt = ST_DATA_ACK;
                end
                ST_ADDR_ACK, ST_DATA_ACK: begin
                    if (scl_fall) nxt = ST_DATA;
                end
                default: nxt = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // shift register, bit counter and ACK drive
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt   <= '0;
            shreg <= '0;
            drive <= 1'b0;
        end else if (start_ev || stop_ev) begin
            cnt   <= '0;
            drive <= 1'b0;
        end else begin
            unique case (state)
                ST_ADDR, ST_DATA: begin
                    if (scl_rise && cnt != LAST) begin
                        shreg <= {shreg[DATA_W-2:0], sda_lvl};
                        cnt   <= cnt + 1'b1;
                    end
                    if (byte_done && ack_ok) drive <= 1'b1;
                end
                ST_ADDR_ACK, ST_DATA_ACK: begin
                    if (scl_fall) begin
                        cnt   <= '0;
                        drive <= 1'b0;
                    end
                end
                default: begin
                    cnt   <= '0;
                    drive <= 1'b0;
                end
            endcase
        end
    end

    // outputs
    always_comb begin
        byte_is_addr = (state == ST_ADDR);
        byte_done    = byte_end && !start_ev && !stop_ev &&
                       (((state == ST_ADDR) && addr_hit) || (state == ST_DATA));
        byte_val     = shreg;
        sda_oe       = drive;
    end
endmodule

// File: rtl/i2c_rx_hostregs.sv
module i2c_rx_hostregs
    import i2c_rx_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              byte_done,
    input  logic              byte_is_addr,
    input  logic [DATA_W-1:0] byte_val,
    input  logic              rd_buf,
    input  logic              clr_ovf,
    input  logic              clr_irq,
    output logic              ack_ok,
    output logic [DATA_W-1:0] rx_buf,
    output logic              buf_full,
    output logic              ovf,
    output logic              rw_stat,
    output logic              irq
);
    rx_action_t act;

    assign act    = rx_decide(buf_full, ovf);
    assign ack_ok = act.ack;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_buf   <= '0;
            buf_full <= 1'b0;
            ovf      <= 1'b0;
            rw_stat  <= 1'b1;
            irq      <= 1'b0;
        end else begin
            if (rd_buf)  buf_full <= 1'b0;
            if (clr_ovf) ovf      <= 1'b0;
            if (clr_irq) irq      <= 1'b0;
            if (byte_done) begin
                irq <= 1'b1;
                if (act.load) begin
                    rx_buf   <= byte_val;
                    buf_full <= 1'b1;
                end
                if (act.set_ov)   ovf     <= 1'b1;
                if (byte_is_addr) rw_stat <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/i2c_rx_slave.sv
module i2c_rx_slave
    import i2c_rx_pkg::*;
#(
    parameter int ADDR_W      = 7,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe,
    input  logic [ADDR_W-1:0] own_addr,
    input  logic              rd_buf,
    input  logic              clr_ovf,
    input  logic              clr_irq,
    output logic [ADDR_W:0]   rx_buf,
    output logic              buf_full,
    output logic              ovf,
    output logic              rw_stat,
    output logic              irq
);
    localparam int DATA_W = ADDR_W + 1;

    logic [1:0]        lvl, rise, fall;
    logic              start_ev, stop_ev;
    logic              ack_ok, byte_done, byte_is_addr;
    logic [DATA_W-1:0] byte_val;
    rx_state_t         fsm_state;

    i2c_line_sync #(.LINES(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .raw   ({sda_i, scl_i}),
        .level (lvl),
        .rise  (rise),
        .fall  (fall)
    );

    i2c_bus_events u_evt (
        .scl_lvl  (lvl[0]),
        .sda_rise (rise[1]),
        .sda_fall (fall[1]),
        .start_ev (start_ev),
        .stop_ev  (stop_ev)
    );

    i2c_rx_fsm #(.ADDR_W(ADDR_W)) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .scl_rise     (rise[0]),
        .scl_fall     (fall[0]),
        .sda_lvl      (lvl[1]),
        .start_ev     (start_ev),
        .stop_ev      (stop_ev),
        .own_addr     (own_addr),
        .ack_ok       (ack_ok),
        .state        (fsm_state),
        .byte_done    (byte_done),
        .byte_is_addr (byte_is_addr),
        .byte_val     (byte_val),
        .sda_oe       (sda_oe)
    );

    i2c_rx_hostregs #(.DATA_W(DATA_W)) u_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .byte_done    (byte_done),
        .byte_is_addr (byte_is_addr),
        .byte_val     (byte_val),
        .rd_buf       (rd_buf),
        .clr_ovf      (clr_ovf),
        .clr_irq      (clr_irq),
        .ack_ok       (ack_ok),
        .rx_buf       (rx_buf),
        .buf_full     (buf_full),
        .ovf          (ovf),
        .rw_stat      (rw_stat),
        .irq          (irq)
    );
endmodule

// File: rtl/i2c_rx_checker.sv
module i2c_rx_checker
    import i2c_rx_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rd_buf,
    input logic              clr_ovf,
    input logic              clr_irq,
    input logic              buf_full,
    input logic              ovf,
    input logic              irq,
    input logic              sda_oe,
    input logic              byte_done,
    input rx_state_t         state,
    input logic [DATA_W-1:0] rx_buf
);
    a_r12_oe_in_ack: assert property (@(posedge clk) disable iff (!rst_n)
        sda_oe |-> (state == ST_ADDR_ACK || state == ST_DATA_ACK));

    a_r6_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        ovf && !clr_ovf |=> ovf);

    a_r9_irq_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        irq && !clr_irq |=> irq);

    a_r9_irq_on_byte: assert property (@(posedge clk) disable iff (!rst_n)
        byte_done |=> irq);

    a_r10_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        rd_buf && !byte_done |=> !buf_full);

    a_r7_full_keeps_buf: assert property (@(posedge clk) disable iff (!rst_n)
        buf_full |=> $stable(rx_buf));

    a_r11_ignore_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_IGNORE |-> !byte_done && !sda_oe);

    a_r8_load_nack: assert property (@(posedge clk) disable iff (!rst_n)
        byte_done && !buf_full && ovf && !clr_ovf |=> buf_full && ovf && !sda_oe);
endmodule

bind i2c_rx_slave i2c_rx_checker #(.DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_buf    (rd_buf),
    .clr_ovf   (clr_ovf),
    .clr_irq   (clr_irq),
    .buf_full  (buf_full),
    .ovf       (ovf),
    .irq       (irq),
    .sda_oe    (sda_oe),
    .byte_done (byte_done),
    .state     (fsm_state),
    .rx_buf    (rx_buf)
);

// File: tb/sim_i2c_rx_slave.sv
module sim_i2c_rx_slave;
    localparam int Q = 8;
    localparam int H = 16;
    localparam logic [6:0] OWN = 7'h52;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       m_scl = 1'b1;
    logic       m_sda = 1'b1;
    logic       rd_buf = 1'b0, clr_ovf = 1'b0, clr_irq = 1'b0;
    logic       sda_oe, buf_full, ovf, rw_stat, irq;
    logic [7:0] rx_buf;
    logic       line;
    int         total = 0, bad = 0;
    bit         done = 1'b0;

    always #4 clk = ~clk;
    assign line = m_sda & ~sda_oe;

    i2c_rx_slave u0 (
        .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(line), .sda_oe(sda_oe),
        .own_addr(OWN), .rd_buf(rd_buf), .clr_ovf(clr_ovf), .clr_irq(clr_irq),
        .rx_buf(rx_buf), .buf_full(buf_full), .ovf(ovf), .rw_stat(rw_stat), .irq(irq)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic bus_start();
        m_sda = 1'b1; tick(Q); m_scl = 1'b1; tick(H);
        m_sda = 1'b0; tick(H); m_scl = 1'b0; tick(Q);
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; tick(Q); m_scl = 1'b1; tick(H);
        m_sda = 1'b1; tick(H);
    endtask

    task automatic send_bits(input logic [7:0] b, input int n);
        for (int i = 7; i > 7 - n; i--) begin
            m_sda = b[i]; tick(Q); m_scl = 1'b1; tick(H); m_scl = 1'b0; tick(Q);
        end
    endtask

    // returns 1 when the ninth-clock line level is low (ACK)
    task automatic send_byte(input logic [7:0] b, output logic acked);
        send_bits(b, 8);
        m_sda = 1'b1; tick(Q); m_scl = 1'b1; tick(H/2);
        acked = ~line;
        tick(H/2); m_scl = 1'b0; tick(Q);
    endtask

    task automatic host_strobe(input int which);
        if (which == 0) rd_buf = 1'b1;
        else if (which == 1) clr_ovf = 1'b1;
        else clr_irq = 1'b1;
        tick(1);
        rd_buf = 1'b0; clr_ovf = 1'b0; clr_irq = 1'b0;
        tick(1);
    endtask

    task automatic host_clean();
        host_strobe(0); host_strobe(1); host_strobe(2);
    endtask

    task automatic t_reset();
        check("R1 buf_full", buf_full, 0);
        check("R1 ovf", ovf, 0);
        check("R1 irq", irq, 0);
        check("R1 sda_oe", sda_oe, 0);
        check("R1 rw_stat", rw_stat, 1);
    endtask

    task automatic t_addr_and_data();
        logic a;
        bus_start();
        send_byte({OWN, 1'b0}, a);
        check("R3 addr ack", a, 1);
        check("R3 rw_stat cleared", rw_stat, 0);
        check("R4 addr in buffer", rx_buf, {OWN, 1'b0});
        check("R9 irq on addr", irq, 1);
        host_strobe(0);
        check("R10 read clears full", buf_full, 0);
        host_strobe(2);
        check("R9 clr_irq", irq, 0);
        send_byte(8'hA5, a);
        check("R5 data ack", a, 1);
        check("R5 data loaded", rx_buf, 8'hA5);
        check("R5 full set", buf_full, 1);
        check("R12 released after ack", sda_oe, 0);
    endtask

    task automatic t_overflow_rows();
        logic a;
        host_strobe(2);
        send_byte(8'h3C, a);
        check("R6 nack", a, 0);
        check("R6 buffer kept", rx_buf, 8'hA5);
        check("R6 ovf set", ovf, 1);
        check("R9 irq on nack", irq, 1);
        send_byte(8'h77, a);
        check("R7 nack", a, 0);
        check("R7 buffer kept", rx_buf, 8'hA5);
        check("R7 ovf stays", ovf, 1);
        host_strobe(0);
        send_byte(8'h99, a);
        check("R8 nack", a, 0);
        check("R8 buffer updated", rx_buf, 8'h99);
        check("R8 full set", buf_full, 1);
        check("R8 ovf stays", ovf, 1);
        host_strobe(1);
        check("R10 clr_ovf", ovf, 0);
        bus_stop();
    endtask

    task automatic t_ignore();
        logic a;
        host_clean();
        bus_start();
        send_byte({OWN ^ 7'h01, 1'b0}, a);
        check("R11 mismatch nack", a, 0);
        check("R11 mismatch irq", irq, 0);
        send_byte(8'h81, a);
        check("R11 data ignored nack", a, 0);
        check("R11 data ignored full", buf_full, 0);
        check("R11 data ignored irq", irq, 0);
        bus_stop();
        bus_start();
        send_byte({OWN, 1'b1}, a);
        check("R11 read nack", a, 0);
        check("R11 read irq", irq, 0);
        check("R11 read full", buf_full, 0);
        bus_stop();
    endtask

    task automatic t_restart_and_stop();
        logic a;
        host_clean();
        bus_start();
        send_byte({OWN, 1'b0}, a);
        host_clean();
        send_bits(8'hFF, 3);
        bus_start();
        send_byte({OWN, 1'b0}, a);
        check("R2 restart addr ack", a, 1);
        host_clean();
        send_byte(8'h5A, a);
        check("R2 data after restart", rx_buf, 8'h5A);
        check("R2 data ack after restart", a, 1);
        bus_stop();
        host_clean();
        send_byte(8'hC3, a);
        check("R2 idle after stop nack", a, 0);
        check("R2 idle after stop irq", irq, 0);
        check("R2 idle after stop buf", rx_buf, 8'h5A);
    endtask

    initial begin
        tick(5);
        rst_n = 1'b1;
        tick(5);
        t_reset();
        t_addr_and_data();
        t_overflow_rows();
        t_ignore();
        t_restart_and_stop();
        tick(20);
        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule